// File: doc/BRIEF.md
# Reset and Power-Fail Supervisor

This block is the digital half of a supply supervisor. It receives synchronous digital indications from analog front-end circuits: supply good, battery backup active, and the power-fail comparator result. It also takes an external active-low reset request. From these it drives an active-low system reset and an active-low power-fail flag. Time is counted in cycles of one fast clock. All lengths are cycle-count parameters, and their defaults are derived from a clock-frequency parameter.

Every reset, whatever its cause, is stretched by one shared recovery timer. The timer has three possible lengths, selected by two configuration bits: a short-recovery bit and a stop bit. Both bits are held inside the block and are loaded through a write strobe. The external request passes through a two-flop synchronizer and a low-time filter, so short glitches never reach the reset output. The power-fail flag is pulled low during backup. It is held high while the supply is good but reset is still being held, and it follows the comparator at all other times.

Top module: `rps_supervisor`

## Requirements
- R1: While `supply_ok` is 0, `rst_out_n` is 0 in the same cycle, and it stays 0 on the clock edge after any cycle in which `supply_ok` was 0.
- R2: After `supply_ok` returns to 1 with no other cause pending, `rst_out_n` goes to 1 on the (N+1)-th rising clock edge, where N is the recovery length in cycles.
- R3: The synchronized `ext_rst_n` must be seen low for at least FILT_CYC consecutive cycles to be accepted; shorter pulses leave `rst_out_n` at 1. After an accepted request, `rst_out_n` returns to 1 on the (N+4)-th edge after `ext_rst_n` returns high (two synchronizer stages, one filter stage, one timer stage).
- R4: The recovery length N is REC_SHORT_CYC when `tr_q`=1 (either `st_q`), REC_MID_CYC when `tr_q`=0 and `st_q`=0, and REC_DEF_CYC when `tr_q`=0 and `st_q`=1.
- R5: While `rst_n` is 0, `tr_q`=0, `st_q`=1 and `rst_out_n`=0. With `supply_ok`=1, the first recovery starts on the first edge after `rst_n` rises, so release comes on edge REC_DEF_CYC+1.
- R6: While `batt_mode` is 1, `pf_out_n` is 0 regardless of the comparator.
- R7: While `batt_mode` is 0, `supply_ok` is 1 and `rst_out_n` is 0, `pf_out_n` is 1. In every other non-backup case, `pf_out_n` equals the inverse of `pf_cmp_low`.
- R8: A new supply drop or an accepted external request during recovery keeps reset asserted. The count then restarts from zero once the cause clears.
- R9: `tr_q` and `st_q` are sampled when each recovery period starts. A change during a running period affects only the next period.
- R10: A clock edge with `cfg_we`=1 loads `cfg_tr_d` and `cfg_st_d` into `tr_q` and `st_q`. Without `cfg_we`, both hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single fast clock |
| rst_n | input | 1 | Synchronous active-low first-power-up reset |
| supply_ok | input | 1 | Supply above trip point |
| batt_mode | input | 1 | Battery backup active |
| pf_cmp_low | input | 1 | Power-fail comparator: monitored input below threshold |
| ext_rst_n | input | 1 | External active-low reset request, asynchronous |
| cfg_we | input | 1 | Write strobe for the recovery-select bits |
| cfg_tr_d | input | 1 | New value of the short-recovery bit |
| cfg_st_d | input | 1 | New value of the stop bit |
| rst_out_n | output | 1 | Active-low system reset |
| pf_out_n | output | 1 | Active-low power-fail flag |
| tr_q | output | 1 | Current short-recovery bit |
| st_q | output | 1 | Current stop bit |

## Verification
The assertions run on every cycle. They check that a supply drop blocks release on the next edge and that the recovery count never passes the length latched at period start. They also check that the latched length stays fixed while a period runs, that the filter accepts only after a low sample, and that the power-fail level is correct in backup and during a held reset. The exact release cycle for each of the three lengths can only be shown by the bench's scenarios. The same holds for the accept-or-reject boundary of the filter across a sweep of pulse widths, for the restart after a mid-recovery interruption, and for the deferred effect of a configuration write.

// File: rtl/rps_pkg.sv
// Shared types for the reset and power-fail supervisor.
package rps_pkg;
    // Phase of the recovery timer.
    typedef enum logic [1:0] {
        PH_HOLD  = 2'd0,   // a reset cause is active
        PH_RECOV = 2'd1,   // cause gone, stretch running
        PH_RUN   = 2'd2    // reset released
    } phase_t;

    // Recovery length selector derived from the two control bits.
    typedef enum logic [1:0] {
        SEL_MID   = 2'd0,
        SEL_DEF   = 2'd1,
        SEL_SHORT = 2'd2
    } rec_sel_t;

    // Map the two control bits onto a selector; the short bit wins.
    function automatic rec_sel_t decode_sel(input logic tr, input logic st);
        if (tr)      return SEL_SHORT;
        else if (st) return SEL_DEF;
        else         return SEL_MID;
    endfunction
endpackage

// File: rtl/rps_req_filter.sv
// External reset request conditioner.
// Synchronizes an asynchronous active-low request with SYNC_STAGES flops,
// then counts consecutive low samples. The request is accepted once
// FILT_CYC low samples have been seen and stays accepted until the
// synchronized input returns high. Assumes FILT_CYC >= 1.
module rps_req_filter #(
    parameter int unsigned FILT_CYC    = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    output logic accept
);
    localparam int unsigned CW = $clog2(FILT_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          low_cnt_q;
    logic                   req_low_s;

    // Synchronizer chain, idles high (no request).
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], req_n};
    end

    assign req_low_s = ~sync_q[SYNC_STAGES-1];

    // Saturating low-time counter, cleared by any high sample.
    always_ff @(posedge clk) begin
        if (!rst_n)                               low_cnt_q <= '0;
        else if (!req_low_s)                      low_cnt_q <= '0;
        else if (low_cnt_q != CW'(FILT_CYC))      low_cnt_q <= low_cnt_q + 1'b1;
    end

    assign accept = (low_cnt_q == CW'(FILT_CYC));

    // R3: acceptance is only ever held over a low synchronized sample.
    a_r3_accept_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(req_low_s));
    // R3: counter never exceeds the threshold.
    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt_q <= CW'(FILT_CYC));
endmodule

// File: rtl/rps_cfg.sv
// Holder for the two recovery-select bits. On first power-up the short bit
// clears and the stop bit sets; afterwards a write strobe loads both.
module rps_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic tr_d,
    input  logic st_d,
    output logic tr_q,
    output logic st_q
);
    // Load on strobe, power-up defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tr_q <= 1'b0;
            st_q <= 1'b1;
        end else if (we) begin
            tr_q <= tr_d;
            st_q <= st_d;
        end
    end

    // R10: bits hold when no write is presented.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable({tr_q, st_q}));
endmodule

// File: rtl/rps_rec_timer.sv
// Shared recovery timer. Holds reset while a cause is active. When the
// cause clears it latches the length chosen by the control bits and
// counts that many cycles before releasing. A cause arriving during
// the count returns it to hold, and counting restarts from zero later.
// Assumes every length parameter is >= 1.
module rps_rec_timer #(
    parameter int unsigned REC_MID_CYC   = 100,
    parameter int unsigned REC_DEF_CYC   = 200,
    parameter int unsigned REC_SHORT_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cause,
    input  logic tr,
    input  logic st,
    output logic released
);
    import rps_pkg::*;

    localparam int unsigned MAX_A = (REC_MID_CYC > REC_DEF_CYC) ? REC_MID_CYC : REC_DEF_CYC;
    localparam int unsigned MAX_L = (MAX_A > REC_SHORT_CYC) ? MAX_A : REC_SHORT_CYC;
    localparam int unsigned CW    = $clog2(MAX_L + 1);

    phase_t        phase_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len_q;
    logic [CW-1:0] len_sel;

    // Translate the control bits into a cycle count.
    always_comb begin
        unique case (decode_sel(tr, st))
            SEL_SHORT: len_sel = CW'(REC_SHORT_CYC);
            SEL_DEF:   len_sel = CW'(REC_DEF_CYC);
            default:   len_sel = CW'(REC_MID_CYC);
        endcase
    end

    // Phase sequencing, counting and length latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_HOLD;
            cnt_q   <= '0;
            len_q   <= CW'(REC_DEF_CYC);
        end else if (cause) begin
            phase_q <= PH_HOLD;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_HOLD: begin
                    phase_q <= PH_RECOV;
                    cnt_q   <= '0;
                    len_q   <= len_sel;
                end
                PH_RECOV: begin
                    if (cnt_q == len_q - 1'b1) phase_q <= PH_RUN;
                    else                       cnt_q   <= cnt_q + 1'b1;
                end
                default: phase_q <= PH_RUN;
            endcase
        end
    end

    assign released = (phase_q == PH_RUN);

    // R8: any cause blocks release on the following edge.
    a_r8_cause_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> !released);
    // R2: release is only reached through a recovery period.
    a_r2_release_via_recov: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(released) |-> $past(phase_q) == PH_RECOV);
    // R2: the count stays below the latched length.
    a_r2_cnt_below_len: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_RECOV |-> cnt_q < len_q);
    // R9: latched length is frozen while a period runs.
    a_r9_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RECOV && $past(phase_q) == PH_RECOV) |-> $stable(len_q));
endmodule

// File: rtl/rps_supervisor.sv
// Reset and power-fail supervisor top. Combines a supply drop and an
// accepted external request into one reset cause, stretches it through
// the shared recovery timer and derives the power-fail flag. Inputs other
// than ext_rst_n are assumed already synchronous to clk.
module rps_supervisor #(
    parameter int unsigned CLK_HZ        = 125_000_000,
    parameter int unsigned FILT_CYC      = (CLK_HZ / 10_000_000 > 0) ? CLK_HZ / 10_000_000 : 1,
    parameter int unsigned REC_MID_CYC   = (CLK_HZ / 1000) * 97,
    parameter int unsigned REC_DEF_CYC   = (CLK_HZ / 1000) * 120,
    parameter int unsigned REC_SHORT_CYC = (CLK_HZ / 1000) * 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic batt_mode,
    input  logic pf_cmp_low,
    input  logic ext_rst_n,
    input  logic cfg_we,
    input  logic cfg_tr_d,
    input  logic cfg_st_d,
    output logic rst_out_n,
    output logic pf_out_n,
    output logic tr_q,
    output logic st_q
);
    logic ext_accept;
    logic cause;
    logic released;

    rps_req_filter #(.FILT_CYC(FILT_CYC), .SYNC_STAGES(2)) u_filt (
        .clk(clk), .rst_n(rst_n), .req_n(ext_rst_n), .accept(ext_accept)
    );

    rps_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .tr_d(cfg_tr_d), .st_d(cfg_st_d),
        .tr_q(tr_q), .st_q(st_q)
    );

    rps_rec_timer #(
        .REC_MID_CYC(REC_MID_CYC), .REC_DEF_CYC(REC_DEF_CYC), .REC_SHORT_CYC(REC_SHORT_CYC)
    ) u_tmr (
        .clk(clk), .rst_n(rst_n), .cause(cause), .tr(tr_q), .st(st_q), .released(released)
    );

    // Unified reset cause.
    assign cause = ~supply_ok | ext_accept;

    // Reset output: immediate on supply loss, otherwise timer driven.
    assign rst_out_n = released & supply_ok & ~ext_accept & rst_n;

    // Power-fail flag: low in backup, high during held reset, else comparator.
    always_comb begin
        if (batt_mode)                   pf_out_n = 1'b0;
        else if (supply_ok && !rst_out_n) pf_out_n = 1'b1;
        else                             pf_out_n = ~pf_cmp_low;
    end

    // R1: a supply drop keeps reset asserted on the next edge.
    a_r1_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !rst_out_n);
    // R6: backup forces the flag low.
    a_r6_backup_low: assert property (@(posedge clk) disable iff (!rst_n)
        batt_mode |-> !pf_out_n);
    // R7: held reset with good supply forces the flag high.
    a_r7_recov_high: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !batt_mode && !released) |-> pf_out_n);
endmodule

// File: tb/sim_rps_supervisor.sv
`timescale 1ns/1ps
module sim_rps_supervisor;
    localparam int F = 4;
    localparam int NM = 12;
    localparam int ND = 20;
    localparam int NS = 5;

    logic clk = 1'b0;
    logic rst_n, supply_ok, batt_mode, pf_cmp_low, ext_rst_n;
    logic cfg_we, cfg_tr_d, cfg_st_d;
    logic rst_out_n, pf_out_n, tr_q, st_q;
    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    rps_supervisor #(
        .CLK_HZ(125_000_000), .FILT_CYC(F),
        .REC_MID_CYC(NM), .REC_DEF_CYC(ND), .REC_SHORT_CYC(NS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .batt_mode(batt_mode),
        .pf_cmp_low(pf_cmp_low), .ext_rst_n(ext_rst_n), .cfg_we(cfg_we),
        .cfg_tr_d(cfg_tr_d), .cfg_st_d(cfg_st_d), .rst_out_n(rst_out_n),
        .pf_out_n(pf_out_n), .tr_q(tr_q), .st_q(st_q)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Count edges until rst_out_n is high.
    task automatic count_release(inout int n);
        while (!rst_out_n && n < 400) begin
            step();
            n++;
        end
    endtask

    task automatic write_cfg(input logic tr, input logic st);
        cfg_we = 1'b1; cfg_tr_d = tr; cfg_st_d = st;
        step();
        cfg_we = 1'b0;
    endtask

    function automatic int len_of(input logic tr, input logic st);
        if (tr) return NS;
        return st ? ND : NM;
    endfunction

    task automatic supply_cycle(input string req, input int exp_len);
        int n;
        supply_ok = 1'b0;
        #1;
        check({req, " reset low on drop (R1)"}, rst_out_n, 0);
        step();
        supply_ok = 1'b1;
        n = 0;
        count_release(n);
        check({req, " release edge"}, n, exp_len + 1);
    endtask

    initial begin
        #(200000 * 8);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        rst_n = 0; supply_ok = 1; batt_mode = 0; pf_cmp_low = 0; ext_rst_n = 1;
        cfg_we = 0; cfg_tr_d = 0; cfg_st_d = 0;
        repeat (3) step();
        // R5: reset state
        check("R5 tr default", tr_q, 0);
        check("R5 st default", st_q, 1);
        check("R5 reset held", rst_out_n, 0);
        check("R7 pf high while held", pf_out_n, 1);
        rst_n = 1;
        n = 0;
        count_release(n);
        check("R5 first release", n, ND + 1);

        // R4/R2/R10: all four control combinations
        for (int s = 0; s < 4; s++) begin
            logic tr, st;
            tr = s[1]; st = s[0];
            write_cfg(tr, st);
            check("R10 tr loaded", tr_q, tr);
            check("R10 st loaded", st_q, st);
            supply_cycle("R4 R2", len_of(tr, st));
        end

        // R3: filter sweep with the short length
        write_cfg(1'b1, 1'b0);
        for (int L = 1; L <= F + 2; L++) begin
            int lows;
            ext_rst_n = 1'b0;
            repeat (L) step();
            ext_rst_n = 1'b1;
            if (L < F) begin
                lows = 0;
                repeat (10) begin
                    step();
                    if (!rst_out_n) lows++;
                end
                check("R3 short pulse ignored", lows, 0);
            end else begin
                int k;
                logic seen;
                k = 0; seen = 1'b0;
                while (!(seen && rst_out_n) && k < 100) begin
                    step();
                    k++;
                    if (!rst_out_n) seen = 1'b1;
                end
                check("R3 accepted stretch", k, NS + 4);
            end
        end

        // R6/R7: flag levels while running
        for (int c = 0; c < 2; c++) begin
            pf_cmp_low = c[0]; batt_mode = 0; #1;
            check("R7 follows comparator", pf_out_n, c == 0 ? 1 : 0);
            batt_mode = 1; #1;
            check("R6 backup low", pf_out_n, 0);
        end
        supply_ok = 0;
        for (int c = 0; c < 2; c++) begin
            pf_cmp_low = c[0]; batt_mode = 0; #1;
            check("R7 supply low follows", pf_out_n, c == 0 ? 1 : 0);
            batt_mode = 1; #1;
            check("R6 backup low, supply low", pf_out_n, 0);
        end
        step();
        batt_mode = 0; pf_cmp_low = 1; supply_ok = 1;
        begin
            int bad;
            bad = 0;
            n = 0;
            while (!rst_out_n && n < 100) begin
                #1;
                if (!pf_out_n) bad++;
                step();
                n++;
            end
            check("R7 forced high in recovery", bad, 0);
            check("R7 follows after release", pf_out_n, 0);
        end
        pf_cmp_low = 0;

        // R8: restart on supply drop mid-recovery
        write_cfg(1'b0, 1'b1);
        supply_ok = 0; step(); supply_ok = 1;
        repeat (6) step();
        check("R8 still held", rst_out_n, 0);
        supply_ok = 0; step(); supply_ok = 1;
        n = 0;
        count_release(n);
        check("R8 restart length", n, ND + 1);

        // R8: restart on external request mid-recovery
        supply_ok = 0; step(); supply_ok = 1;
        repeat (3) step();
        ext_rst_n = 0; repeat (F + 1) step(); ext_rst_n = 1;
        n = 0;
        count_release(n);
        check("R8 ext restart length", n, ND + 4);

        // R9: change during a period affects only the next one
        write_cfg(1'b0, 1'b0);
        supply_ok = 0; step(); supply_ok = 1;
        n = 0;
        step(); n++;
        step(); n++;
        write_cfg(1'b1, 1'b0); n++;
        count_release(n);
        check("R9 running period unchanged", n, NM + 1);
        supply_cycle("R9 next period", NS);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule